// File: doc/BRIEF.md
# Phase-Synchronized Up-Down PWM Timebase

This block is a single PWM time-base channel. A 16-bit counter runs in one of four modes (up-down, up-only, down-only, hold) against an active period value. An external sync pulse can reload the counter from a phase register and force its direction from a phase-direction bit. This lets several channels be phase-locked to a master. A loaded phase above the period is never clamped. When the direction bit says up, the counter keeps rising past the period until it wraps at full scale or the next sync arrives.

The period and compare values are written into shadow registers and become active only at defined counter events. This keeps a running waveform glitch-free. An action stage drives `pwm_a` from compare matches. Two event outputs are produced: a sync output for daisy-chaining and a start-of-conversion pulse on every period event. All outputs are registered.

Software writes a 2-bit address and a 16-bit data word. Address 0 is the period shadow, 1 the compare shadow, 2 the phase value, and 3 the control word. The control word has bit 0 phase-load enable, bit 1 phase direction (1 = up), bit 2 sync-output select (0 = pulse at counter zero, 1 = pass sync input through), and bits 4:3 counter mode (00 up-down, 01 up, 10 down, 11 hold).

Top module: `pwm_phase_timebase`

## Requirements
- R1: While `rst` is high, at each clock edge the count is cleared, the direction is set to up (`count_up` = 1), and `pwm_a`, `sync_out` and `soc_pulse` are driven low.
- R2: In up-down mode with no sync load, the count increments by one per clock while going up until it equals the active period. It then turns down and decrements to zero, where it turns up again. A zero period holds the count at zero.
- R3: With phase loading enabled (control bit 0 = 1), a high `sync_in` at a clock edge loads the count with the phase value. In up-down mode the same edge sets the direction from control bit 1. With control bit 0 = 0, `sync_in` has no effect on the count or the direction.
- R4: A phase value above the active period, loaded with direction up, keeps counting up with no clamp. It passes 0xFFFF to 0 and carries on up.
- R5: When a sync load and a count-equals-period condition fall on the same edge, the sync load and its direction bit win.
- R6: A period write only updates the shadow. The shadow moves to the active period on an edge where the count is zero.
- R7: The compare shadow moves to the active compare value on an edge where the count equals zero or the active period.
- R8: On an edge where the count equals the active compare value, `pwm_a` becomes 1 if counting up and 0 if counting down. A compare value that a sync load jumps over causes no change.
- R9: With control bit 2 = 0, `sync_out` is high for the cycle after each edge where the count is zero. With bit 2 = 1, `sync_out` is `sync_in` delayed by one clock.
- R10: `soc_pulse` is high for the cycle after every edge where the count equals the active period, except in hold mode.
- R11: Up mode (01) goes from the period back to 0. Down mode (10) goes from 0 back to the period. Hold mode (11) keeps the count still unless a sync load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 compare, 2 phase, 3 control |
| wr_data | input | 16 | Write data |
| sync_in | input | 1 | External synchronization pulse |
| pwm_a | output | 1 | PWM output from the action stage |
| sync_out | output | 1 | Sync output, zero-event or pass-through |
| soc_pulse | output | 1 | Start-of-conversion pulse on period events |
| count | output | 16 | Live counter value |
| count_up | output | 1 | Live count direction (1 = up) |

## Verification
The in-RTL assertions check on every cycle the reset state, the single-step increment in up-down mode, the effect of a phase load, the absence of a clamp above the period, the priority of sync over the period turn, the set action on an up-count match, and the period-event conversion pulse. The bench's scenarios are what show the shadow timing of period and compare changes, a compare value skipped by a sync jump, the wrap through 0xFFFF, both sync-output selections and the up, down and hold modes. A behavioural model tracks all five outputs each clock. Directed probes are placed at the exact cycles where those effects appear.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

  typedef enum logic [1:0] {
    MODE_UPDOWN = 2'd0,
    MODE_UP     = 2'd1,
    MODE_DOWN   = 2'd2,
    MODE_HOLD   = 2'd3
  } cnt_mode_e;

  // control word layout: [4:3] mode, [2] sync select, [1] phase dir, [0] phase enable
  typedef struct packed {
    cnt_mode_e mode;
    logic      sync_sel;
    logic      phase_dir;
    logic      phase_en;
  } ctrl_t;

  localparam int CTRL_W     = $bits(ctrl_t);
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_PERIOD  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_COMPARE = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_PHASE   = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL    = 2'd3;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic [CNT_W-1:0]      prd_shd,
  output logic [CNT_W-1:0]      cmp_shd,
  output logic [CNT_W-1:0]      phase,
  output ctrl_t                 ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_shd <= '0;
      cmp_shd <= '0;
      phase   <= '0;
      ctrl    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PERIOD:  prd_shd <= wr_data;
        ADDR_COMPARE: cmp_shd <= wr_data;
        ADDR_PHASE:   phase   <= wr_data;
        default:      ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
      endcase
    end
  end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] prd_shd,
  input  logic [CNT_W-1:0] phase,
  input  cnt_mode_e        mode,
  input  logic             phase_dir,
  input  logic             phase_en,
  input  logic             sync_in,
  output logic [CNT_W-1:0] ctr,
  output logic [CNT_W-1:0] prd_act,
  output logic             dir
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             load;
  logic [CNT_W-1:0] ctr_n;
  logic             dir_n;
  logic             at_prd;
  logic             at_zero;

  assign load    = sync_in && phase_en;
  assign at_prd  = (ctr == prd_act);
  assign at_zero = (ctr == ZERO);

  always_comb begin
    ctr_n = ctr;
    dir_n = dir;
    unique case (mode)
      MODE_UPDOWN: begin
        if (load) begin
          ctr_n = phase;
          dir_n = phase_dir;
        end else if (dir) begin
          if (at_prd) begin
            dir_n = 1'b0;
            ctr_n = (prd_act == ZERO) ? ZERO : ctr - ONE;
          end else begin
            ctr_n = ctr + ONE;
          end
        end else begin
          if (at_zero) begin
            dir_n = 1'b1;
            ctr_n = (prd_act == ZERO) ? ZERO : ONE;
          end else begin
            ctr_n = ctr - ONE;
          end
        end
      end
      MODE_UP: begin
        dir_n = 1'b1;
        ctr_n = load ? phase : (at_prd ? ZERO : ctr + ONE);
      end
      MODE_DOWN: begin
        dir_n = 1'b0;
        ctr_n = load ? phase : (at_zero ? prd_act : ctr - ONE);
      end
      default: begin
        ctr_n = load ? phase : ctr;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr     <= '0;
      dir     <= 1'b1;
      prd_act <= '0;
    end else begin
      ctr <= ctr_n;
      dir <= dir_n;
      if (at_zero) prd_act <= prd_shd;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ctr == ZERO && dir));

  assert_updown_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UPDOWN && !load && dir && !at_prd) |=> (ctr == $past(ctr) + ONE));

  assert_sync_load_R3: assert property (@(posedge clk) disable iff (rst)
    (load && mode == MODE_UPDOWN) |=> (ctr == $past(phase) && dir == $past(phase_dir)));

  assert_no_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UPDOWN && !load && dir && ctr > prd_act) |=> dir);

  assert_sync_beats_period_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UPDOWN && load && at_prd && phase_dir) |=> dir);

endmodule

// File: rtl/pwm_action.sv
module pwm_action #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cmp_shd,
  input  logic [CNT_W-1:0] ctr,
  input  logic [CNT_W-1:0] prd_act,
  input  logic             dir,
  output logic             pwm_a
);

  logic [CNT_W-1:0] cmp_act;
  logic             hit;

  assign hit = (ctr == cmp_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_act <= '0;
      pwm_a   <= 1'b0;
    end else begin
      if (ctr == '0 || ctr == prd_act) cmp_act <= cmp_shd;
      if (hit) pwm_a <= dir;
    end
  end

  assert_set_on_up_R8: assert property (@(posedge clk) disable iff (rst)
    (hit && dir) |=> pwm_a);

  assert_clear_on_down_R8: assert property (@(posedge clk) disable iff (rst)
    (hit && !dir) |=> !pwm_a);

endmodule

// File: rtl/pwm_events.sv
module pwm_events #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ctr,
  input  logic [CNT_W-1:0] prd_act,
  input  logic             sync_in,
  input  logic             sync_sel,
  input  logic             hold,
  output logic             sync_out,
  output logic             soc_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_out  <= 1'b0;
      soc_pulse <= 1'b0;
    end else begin
      sync_out  <= sync_sel ? sync_in : (ctr == '0);
      soc_pulse <= (ctr == prd_act) && !hold;
    end
  end

  assert_soc_on_period_R10: assert property (@(posedge clk) disable iff (rst)
    (ctr == prd_act && !hold) |=> soc_pulse);

  assert_sync_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (sync_sel && sync_in) |=> sync_out);

endmodule

// File: rtl/pwm_phase_timebase.sv
module pwm_phase_timebase
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  input  logic                  sync_in,
  output logic                  pwm_a,
  output logic                  sync_out,
  output logic                  soc_pulse,
  output logic [CNT_W-1:0]      count,
  output logic                  count_up
);

  logic [CNT_W-1:0] prd_shd;
  logic [CNT_W-1:0] cmp_shd;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] prd_act;
  ctrl_t            ctrl;

  pwm_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .prd_shd (prd_shd),
    .cmp_shd (cmp_shd),
    .phase   (phase),
    .ctrl    (ctrl)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .prd_shd   (prd_shd),
    .phase     (phase),
    .mode      (ctrl.mode),
    .phase_dir (ctrl.phase_dir),
    .phase_en  (ctrl.phase_en),
    .sync_in   (sync_in),
    .ctr       (count),
    .prd_act   (prd_act),
    .dir       (count_up)
  );

  pwm_action #(.CNT_W(CNT_W)) u_act (
    .clk     (clk),
    .rst     (rst),
    .cmp_shd (cmp_shd),
    .ctr     (count),
    .prd_act (prd_act),
    .dir     (count_up),
    .pwm_a   (pwm_a)
  );

  pwm_events #(.CNT_W(CNT_W)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .ctr       (count),
    .prd_act   (prd_act),
    .sync_in   (sync_in),
    .sync_sel  (ctrl.sync_sel),
    .hold      (ctrl.mode == MODE_HOLD),
    .sync_out  (sync_out),
    .soc_pulse (soc_pulse)
  );

endmodule

// File: tb/tb_pwm_phase_timebase.sv
module tb_pwm_phase_timebase;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         sync_in = 1'b0;
  logic         pwm_a, sync_out, soc_pulse, count_up;
  logic [W-1:0] count;

  pwm_phase_timebase #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .pwm_a(pwm_a), .sync_out(sync_out), .soc_pulse(soc_pulse),
    .count(count), .count_up(count_up)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    started = 1'b0;
  bit    finished = 1'b0;

  // behavioural reference state
  logic [W-1:0] m_prds, m_prda, m_cmps, m_cmpa, m_phase, m_ctr;
  logic         m_dir, m_pwm, m_so, m_soc, m_en, m_pdir, m_sel;
  logic [1:0]   m_mode;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [W-1:0] cn;
    logic         dn, ld;
    if (rst) begin
      m_prds = 0; m_prda = 0; m_cmps = 0; m_cmpa = 0; m_phase = 0; m_ctr = 0;
      m_dir = 1; m_pwm = 0; m_so = 0; m_soc = 0;
      m_en = 0; m_pdir = 0; m_sel = 0; m_mode = 0;
    end else begin
      ld = sync_in && m_en;
      cn = m_ctr; dn = m_dir;
      if (m_mode == 2'd0) begin
        if (ld) begin cn = m_phase; dn = m_pdir; end
        else if (m_dir) begin
          if (m_ctr == m_prda) begin dn = 0; cn = (m_prda == 0) ? 16'd0 : m_ctr - 16'd1; end
          else cn = m_ctr + 16'd1;
        end else begin
          if (m_ctr == 0) begin dn = 1; cn = (m_prda == 0) ? 16'd0 : 16'd1; end
          else cn = m_ctr - 16'd1;
        end
      end else if (m_mode == 2'd1) begin
        dn = 1;
        if (ld) cn = m_phase; else if (m_ctr == m_prda) cn = 0; else cn = m_ctr + 16'd1;
      end else if (m_mode == 2'd2) begin
        dn = 0;
        if (ld) cn = m_phase; else if (m_ctr == 0) cn = m_prda; else cn = m_ctr - 16'd1;
      end else begin
        if (ld) cn = m_phase;
      end
      if (m_ctr == m_cmpa) m_pwm = m_dir;
      m_so  = m_sel ? sync_in : (m_ctr == 0);
      m_soc = (m_ctr == m_prda) && (m_mode != 2'd3);
      if (m_ctr == 0 || m_ctr == m_prda) m_cmpa = m_cmps;
      if (m_ctr == 0) m_prda = m_prds;
      m_ctr = cn; m_dir = dn;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_prds = wr_data;
          2'd1: m_cmps = wr_data;
          2'd2: m_phase = wr_data;
          default: begin
            m_en = wr_data[0]; m_pdir = wr_data[1]; m_sel = wr_data[2]; m_mode = wr_data[4:3];
          end
        endcase
      end
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      check(cur_req, "count", count, m_ctr);
      check(cur_req, "count_up", count_up, m_dir);
      check(cur_req, "pwm_a", pwm_a, m_pwm);
      check(cur_req, "sync_out", sync_out, m_so);
      check(cur_req, "soc_pulse", soc_pulse, m_soc);
    end
  end

  function automatic logic [W-1:0] cw(input int mode, input bit sel, input bit pdir, input bit en);
    return W'({mode[1:0], sel, pdir, en});
  endfunction

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ctr(input int v, input int d, output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (count == v && (d < 0 || count_up == d)) begin ok = 1; break; end
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    bit ok;
    int mx;
    idle(3);
    cur_req = "R1";
    check("R1", "reset count", count, 0);
    check("R1", "reset dir", count_up, 1);
    check("R1", "reset pwm", pwm_a, 0);
    check("R1", "reset sync_out", sync_out, 0);
    check("R1", "reset soc", soc_pulse, 0);
    rst = 0;

    // R2: basic up-down triangle
    cur_req = "R2";
    wr(2'd0, 16'd10);
    wr(2'd1, 16'd4);
    mx = 0;
    repeat (60) begin @(negedge clk); if (count > mx) mx = count; end
    check("R2", "peak count", mx, 10);

    // R7: compare shadow change mid-run
    cur_req = "R7";
    wr(2'd1, 16'd3);
    idle(40);

    // R6: period shadow takes effect only at zero
    cur_req = "R6";
    wait_ctr(3, 1, ok);
    wr(2'd0, 16'd6);
    wait_ctr(10, -1, ok);
    check("R6", "old period still reached", ok, 1);
    idle(25);
    mx = 0;
    repeat (30) begin @(negedge clk); if (count > mx) mx = count; end
    check("R6", "new peak", mx, 6);

    // R3: sync ignored when disabled, then loads when enabled
    cur_req = "R3";
    wr(2'd2, 16'd2);
    wr(2'd3, cw(0, 0, 0, 0));
    wait_ctr(5, 1, ok);
    sync_in = 1; @(negedge clk); sync_in = 0;
    check("R3", "disabled sync count", count, 6);
    wr(2'd3, cw(0, 0, 0, 1));
    wait_ctr(1, 1, ok);
    sync_in = 1; @(negedge clk); sync_in = 0;
    check("R3", "loaded count", count, 2);
    check("R3", "loaded dir", count_up, 0);

    // R4: phase above period, counting up through full scale
    cur_req = "R4";
    wr(2'd2, 16'hFFFA);
    wr(2'd3, cw(0, 0, 1, 1));
    sync_in = 1; @(negedge clk); sync_in = 0;
    check("R4", "loaded high count", count, 16'hFFFA);
    idle(6);
    check("R4", "wrapped count", count, 0);
    check("R4", "still up", count_up, 1);

    // R5: sync coinciding with period match
    cur_req = "R5";
    wr(2'd2, 16'd3);
    wait_ctr(6, 1, ok);
    sync_in = 1; @(negedge clk); sync_in = 0;
    check("R5", "sync wins count", count, 3);
    check("R5", "sync wins dir", count_up, 1);

    // R8: compare value jumped over by a sync load
    cur_req = "R8";
    wr(2'd2, 16'd5);
    wait_ctr(1, 1, ok);
    check("R8", "pwm before jump", pwm_a, 0);
    sync_in = 1; @(negedge clk); sync_in = 0;
    for (int k = 0; k < 4; k++) begin
      check("R8", "pwm after skipped compare", pwm_a, 0);
      @(negedge clk);
    end
    idle(20);

    // R9: sync output selection
    cur_req = "R9";
    wr(2'd3, cw(0, 1, 1, 0));
    idle(2);
    sync_in = 1; @(negedge clk); sync_in = 0;
    check("R9", "pass-through high", sync_out, 1);
    @(negedge clk);
    check("R9", "pass-through low", sync_out, 0);
    wr(2'd3, cw(0, 0, 1, 0));
    wait_ctr(0, -1, ok);
    @(negedge clk);
    check("R9", "zero pulse", sync_out, 1);

    // R10: start of conversion on period event
    cur_req = "R10";
    wait_ctr(6, -1, ok);
    @(negedge clk);
    check("R10", "soc after period", soc_pulse, 1);

    // R11: other counting modes
    cur_req = "R11";
    wr(2'd3, cw(1, 0, 0, 0));
    idle(20);
    wait_ctr(6, -1, ok);
    @(negedge clk);
    check("R11", "up mode wrap", count, 0);
    wr(2'd3, cw(2, 0, 0, 0));
    idle(10);
    wait_ctr(0, -1, ok);
    @(negedge clk);
    check("R11", "down mode reload", count, 6);
    wr(2'd3, cw(3, 0, 0, 0));
    idle(2);
    mx = count;
    idle(5);
    check("R11", "hold count", count, mx);
    check("R10", "no soc in hold", soc_pulse, 0);

    // mixed traffic, checked cycle by cycle against the model
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r == 0) wr(2'd0, W'($urandom_range(3, 20)));
      else if (r == 1) wr(2'd1, W'($urandom_range(0, 22)));
      else if (r == 2) wr(2'd2, W'($urandom_range(0, 25)));
      else if (r == 3) wr(2'd3, cw(($urandom_range(0, 4) == 0) ? $urandom_range(0, 3) : 0,
                                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))));
      else begin
        @(negedge clk);
        sync_in = ($urandom_range(0, 5) == 0);
      end
    end
    @(negedge clk); sync_in = 0;
    idle(4);
    summary();
  end

endmodule